// File: doc/BRIEF.md
# Twisted-Ring Stepped Sine Generator

This block produces a coarse, staircase approximation of a sine wave from a clock. Inside it is an N-stage twisted-ring shift chain: on every enabled clock the chain moves one place, and the inverted output of the last stage is fed back into the first. The chain therefore fills with ones one stage at a time and then empties one stage at a time. The full pattern repeats every 2N clocks.

Every stage except the last carries a fixed digital weight. The output is the sum of the weights of the stages that are currently set. The weights are the differences between samples of a half sine wave taken at equally spaced phases, so the sum climbs from zero to full scale along a sine-shaped curve and then falls back along the same curve. The last stage has no weight, which means the code stays at full scale for two clocks and at zero for two clocks. The first stage, which takes the inverted feedback, carries the smallest weight. A downstream DAC and reconstruction filter turn the code into an analog sine wave.

Top module: `jcsine_gen`

## Requirements
- R1: On each clock where `en` is high and `rst` is low, `ring_state` shifts toward higher indices, and bit 0 takes the inverse of the previous bit N-1. Exactly one stage changes per clock.
- R2: With `en` held high, `ring_state` returns to any given value after exactly 2N clocks and not before.
- R3: `rst` is synchronous and active high, and it takes priority over `en`. After reset, bits 0 to N/2-1 of `ring_state` are set and the rest are clear. `amp_code` then lies strictly above AMPL/2 and strictly below AMPL.
- R4: `amp_code` equals the sum of the weights of the set stages in the current `ring_state`. With all stages set it is exactly AMPL, and with all stages clear it is 0.
- R5: Stage N-1 has no weight. `amp_code` holds at AMPL for exactly two consecutive clocks and at 0 for exactly two consecutive clocks in each period.
- R6: Between the holds, `amp_code` makes N-1 strictly increasing steps from 0 to AMPL and then N-1 strictly decreasing steps from AMPL to 0.
- R7: Stage 0 carries the smallest step. Step sizes do not shrink up to the middle of the rising run and do not grow after it.
- R8: The k-th falling step has the same size as the k-th rising step, because clearing proceeds in the same stage order as setting.
- R9: While `en` is low and `rst` is low, `ring_state` and `amp_code` keep their values.
- R10: The reset value of `amp_code` equals the level that the rising run reaches after N/2 steps from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the ring by one stage this clock |
| ring_state | output | N | Stage outputs; bit k is stage k, bit N-1 is the unweighted stage |
| amp_code | output | CODE_W | Registered amplitude code, 0 to AMPL |

## Verification
The assertions watch, on every cycle, the properties that can be seen from one clock to the next. Exactly one stage changes per enabled clock. Enable low freezes both outputs. Reset loads the half-filled pattern. The code is AMPL whenever the ring is full and 0 whenever it is empty. The code never falls while the last stage is clear and never rises while it is set. The bench scenarios cover what needs a whole period: the exact 2N repeat, the two-clock dwell at each extreme, strict monotonic steps, the smallest first step with growth toward the middle, equality of rising and falling steps, and the reset level matching the mid-run level.

// File: rtl/jcsine_pkg.sv
package jcsine_pkg;

   localparam real PI = 3.14159265358979323846;

   // odd-power series, accurate over [-pi/2, pi/2]
   function automatic real jc_sine(input real x);
      real term;
      real acc;
      term = x;
      acc  = x;
      for (int i = 1; i < 12; i++) begin
         term = -term * x * x / real'((2 * i) * (2 * i + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // level reached after j weighted stages are set, 0..ampl
   function automatic int jc_level(input int j, input int n, input int ampl);
      real th;
      real v;
      th = -PI / 2.0 + PI * real'(j) / real'(n - 1);
      v  = real'(ampl) * (1.0 + jc_sine(th)) / 2.0;
      return $rtoi(v + 0.5);
   endfunction

   // weight of stage k (k < n-1)
   function automatic int jc_weight(input int k, input int n, input int ampl);
      return jc_level(k + 1, n, ampl) - jc_level(k, n, ampl);
   endfunction

endpackage

// File: rtl/jcsine_ring.sv
module jcsine_ring #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   output logic [N-1:0] state_q,
   output logic [N-2:0] nxt_weighted
);

   localparam logic [N-1:0] RST_PAT = {{(N/2){1'b0}}, {(N/2){1'b1}}};

   logic [N-1:0] state_d;

   always_comb begin
      if (rst)
         state_d = RST_PAT;
      else if (en)
         state_d = {state_q[N-2:0], ~state_q[N-1]};
      else
         state_d = state_q;
   end

   assign nxt_weighted = state_d[N-2:0];

   always_ff @(posedge clk) begin
      state_q <= state_d;
   end

   // R1: one stage flips per enabled clock
   p_one_stage_r1: assert property (@(posedge clk) disable iff (rst)
      en |=> $countones(state_q ^ $past(state_q)) == 1);

   // R9: frozen while enable is low
   p_ring_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(state_q));

   // R3: reset loads the half-filled pattern
   p_reset_pat_r3: assert property (@(posedge clk)
      rst |=> state_q == RST_PAT);

endmodule

// File: rtl/jcsine_sum.sv
module jcsine_sum
   import jcsine_pkg::*;
#(
   parameter int N    = 10,
   parameter int AMPL = 1023,
   parameter int W    = 10
) (
   input  logic [N-2:0] stages,
   output logic [W-1:0] total
);

   logic [W-1:0] acc [N-1];

   for (genvar k = 0; k < N - 1; k++) begin : g_stage
      localparam int WK = jc_weight(k, N, AMPL);
      if (k == 0) begin : g_first
         assign acc[k] = stages[k] ? W'(WK) : '0;
      end else begin : g_next
         assign acc[k] = acc[k-1] + (stages[k] ? W'(WK) : '0);
      end
   end

   assign total = acc[N-2];

endmodule

// File: rtl/jcsine_gen.sv
module jcsine_gen #(
   parameter  int N      = 10,
   parameter  int AMPL   = 1023,
   localparam int CODE_W = $clog2(AMPL + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   output logic [N-1:0]      ring_state,
   output logic [CODE_W-1:0] amp_code
);

   if (N < 4 || (N % 2) != 0) begin : g_bad_n
      $error("jcsine_gen: N must be even and at least 4");
   end
   if (AMPL < 2 * N) begin : g_bad_ampl
      $error("jcsine_gen: AMPL too small for distinct steps");
   end

   logic [N-2:0]      nxt_w;
   logic [CODE_W-1:0] code_d;

   jcsine_ring #(.N(N)) u_ring (
      .clk          (clk),
      .rst          (rst),
      .en           (en),
      .state_q      (ring_state),
      .nxt_weighted (nxt_w)
   );

   jcsine_sum #(.N(N), .AMPL(AMPL), .W(CODE_W)) u_sum (
      .stages (nxt_w),
      .total  (code_d)
   );

   always_ff @(posedge clk) begin
      amp_code <= code_d;
   end

   // R4: full ring is full scale
   p_full_scale_r4: assert property (@(posedge clk) disable iff (rst)
      (&ring_state) |-> amp_code == CODE_W'(AMPL));

   // R4: empty ring is zero
   p_zero_scale_r4: assert property (@(posedge clk) disable iff (rst)
      (ring_state == '0) |-> amp_code == '0);

   // R6: rising half never falls
   p_rise_r6: assert property (@(posedge clk) disable iff (rst)
      (en && !ring_state[N-1]) |=> amp_code >= $past(amp_code));

   // R6: falling half never rises
   p_fall_r6: assert property (@(posedge clk) disable iff (rst)
      (en && ring_state[N-1]) |=> amp_code <= $past(amp_code));

   // R9: code frozen while enable is low
   p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(amp_code));

endmodule

// File: tb/jcsine_gen_test.sv
module jcsine_gen_test;

   localparam int N    = 10;
   localparam int AMPL = 1023;
   localparam int CW   = $clog2(AMPL + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic [N-1:0]  ring_state;
   logic [CW-1:0] amp_code;

   int checks = 0;
   int errors = 0;
   int rst_code = 0;
   int codes [0:2*N];
   logic [N-1:0] rings [0:2*N];

   always #2 clk = ~clk;

   jcsine_gen #(.N(N), .AMPL(AMPL)) uut (
      .clk(clk), .rst(rst), .en(en),
      .ring_state(ring_state), .amp_code(amp_code)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1; en = 1'b1;
      tick();
      rst = 1'b0;
      chk(ring_state == N'((1 << (N/2)) - 1), "R3", "reset ring pattern",
          int'(ring_state), (1 << (N/2)) - 1);
      chk(int'(amp_code) > AMPL / 2, "R3", "reset code above mid",
          int'(amp_code), AMPL / 2 + 1);
      chk(int'(amp_code) < AMPL, "R3", "reset code below full",
          int'(amp_code), AMPL - 1);
      rst_code = int'(amp_code);
   endtask

   task automatic t_period();
      int n;
      n = 0;
      en = 1'b1;
      while (ring_state != '0 && n < 2 * N) begin
         tick();
         n++;
      end
      chk(ring_state == '0, "R2", "empty ring reached", int'(ring_state), 0);
      chk(amp_code == '0, "R4", "code at empty ring", int'(amp_code), 0);
      codes[0] = int'(amp_code);
      rings[0] = ring_state;
      for (int j = 1; j <= 2 * N; j++) begin
         tick();
         codes[j] = int'(amp_code);
         rings[j] = ring_state;
      end
      chk(rings[2*N] == rings[0], "R2", "state repeats after 2N",
          int'(rings[2*N]), int'(rings[0]));
      for (int j = 1; j < 2 * N; j++)
         if (rings[j] == rings[0])
            chk(1'b0, "R2", "early repeat index", j, 2 * N);
      for (int j = 1; j <= 2 * N; j++) begin
         chk($countones(rings[j] ^ rings[j-1]) == 1, "R1", "one stage changes",
             $countones(rings[j] ^ rings[j-1]), 1);
         chk(rings[j] == {rings[j-1][N-2:0], ~rings[j-1][N-1]}, "R1",
             "twisted shift", int'(rings[j]),
             int'({rings[j-1][N-2:0], ~rings[j-1][N-1]}));
      end
      chk(codes[N] == AMPL, "R4", "code at full ring", codes[N], AMPL);
      chk(codes[N-1] == AMPL && codes[N-2] < AMPL && codes[N+1] < AMPL,
          "R5", "two-clock top hold", codes[N+1], AMPL - 1);
      chk(codes[2*N-1] == 0 && codes[2*N-2] > 0 && codes[1] > 0,
          "R5", "two-clock bottom hold", codes[2*N-2], 1);
   endtask

   task automatic t_shape();
      int r [1:N-1];
      int f [1:N-1];
      for (int k = 1; k <= N - 1; k++) begin
         r[k] = codes[k] - codes[k-1];
         f[k] = codes[N+k-1] - codes[N+k];
      end
      for (int k = 1; k <= N - 1; k++) begin
         chk(r[k] > 0, "R6", "rising step positive", r[k], 1);
         chk(f[k] > 0, "R6", "falling step positive", f[k], 1);
         chk(r[k] == f[k], "R8", "rise/fall step match", f[k], r[k]);
         chk(r[1] <= r[k], "R7", "first step smallest", r[1], r[k]);
      end
      for (int k = 2; k <= N / 2; k++)
         chk(r[k] >= r[k-1], "R7", "steps grow to middle", r[k], r[k-1]);
      for (int k = N / 2 + 1; k <= N - 1; k++)
         chk(r[k] <= r[k-1], "R7", "steps shrink after middle", r[k], r[k-1]);
      chk(rst_code == codes[N/2], "R10", "reset level vs run level",
          rst_code, codes[N/2]);
   endtask

   task automatic t_enable();
      logic [N-1:0] rs;
      int c;
      en = 1'b1;
      tick(); tick(); tick();
      rs = ring_state;
      c  = int'(amp_code);
      en = 1'b0;
      for (int j = 0; j < 4; j++) begin
         tick();
         chk(ring_state == rs, "R9", "ring frozen", int'(ring_state), int'(rs));
         chk(int'(amp_code) == c, "R9", "code frozen", int'(amp_code), c);
      end
   endtask

   task automatic t_reset_priority();
      en = 1'b0;
      rst = 1'b1;
      tick();
      rst = 1'b0;
      chk(ring_state == N'((1 << (N/2)) - 1), "R3", "reset beats enable low",
          int'(ring_state), (1 << (N/2)) - 1);
      chk(int'(amp_code) == rst_code, "R3", "reset code repeat",
          int'(amp_code), rst_code);
   endtask

   initial begin
      #(4 * 100000);
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_period();
      t_shape();
      t_enable();
      t_reset_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule